// File: doc/BRIEF.md
# CompactFlash Bootstrap Load Sequencer

This block copies the first sectors of a CompactFlash card, run in true-IDE mode with an 8-bit register interface, into system RAM straight after reset. The processor needs no boot ROM for this step. A fixed sequence in logic does the work. It waits for the card to leave the busy state and selects drive 0 in LBA mode. It switches the card to 8-bit transfers and points the card at sector 0 with a parameterised sector count. It then issues the read command and moves every data byte into RAM at consecutive addresses, starting from a parameterised base, for as long as the card requests data.

When the card reports that the transfer is complete, the block raises a done flag and releases the processor reset one cycle later. If the card reports an error at the end of a command, the sequence stops. The block then raises an error output and keeps the processor in reset.

All register accesses use separate read and write strobes. The address setup time, the strobe width and the address hold time are each set by a parameter in clock cycles. Read data is sampled on the last clock of the strobe.

Top module: `cf_boot_loader`

## Requirements
- R1: While `rst_n` is low, the outputs are idle: `cpu_rst_n`=0, `boot_done`=0, `boot_err`=0, `ide_rd_n`=1, `ide_wr_n`=1 and `ram_we`=0.
- R2: The block writes no card register until a status read (offset 7) has returned bit 7 (busy) as 0. While busy is 1, the other status bits are ignored.
- R3: The configuration writes come in this order: 0xE0 to offset 6 (drive 0, LBA mode, LBA bits 27:24 zero), then 0x01 to offset 1, then 0xEF to offset 7. After these writes, status is polled until busy clears.
- R4: Next come 0x00 to offsets 3, 4 and 5 (LBA low, middle and high), then the sector count `SECTORS` to offset 2, then the read command 0x20 to offset 7. Exactly eight register writes are made in total.
- R5: After each status read that has busy clear, a set bit 3 (data request) causes one read of offset 0, followed by a new status poll. Busy clear with bit 3 clear ends the transfer. Offset 0 is never read while data request is clear.
- R6: Each data byte is written to RAM with one `ram_we` pulse. The first byte goes to address `LOAD_BASE` and each later byte goes one address higher. Exactly 512×`SECTORS` bytes are written, and no address outside that range is written.
- R7: When the transfer ends, `boot_done` goes high and stays high. `cpu_rst_n` goes high one cycle later, and `boot_err` stays low.
- R8: If status bit 0 (error) is set when busy clears after a command, the block stops. `boot_err` goes high and stays high, `cpu_rst_n` stays low, and no further register write or RAM write follows.
- R9: The strobes `ide_rd_n` and `ide_wr_n` are never low together. Each strobe stays low for exactly `STROBE_CYC` cycles. `ide_addr` is stable for at least `SETUP_CYC` cycles before a strobe falls and for at least `HOLD_CYC` cycles after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts a new boot load |
| ide_addr | output | 3 | Card register offset |
| ide_rd_n | output | 1 | Active-low register read strobe |
| ide_wr_n | output | 1 | Active-low register write strobe |
| ide_dout | output | 8 | Data driven to the card on writes |
| ide_doe | output | 1 | Data output enable for an external bus buffer |
| ide_din | input | 8 | Data read from the card |
| ram_we | output | 1 | RAM write pulse, one per loaded byte |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| boot_done | output | 1 | Load finished without error |
| boot_err | output | 1 | Card reported an error, load stopped |
| cpu_rst_n | output | 1 | Processor reset, released after a good load |

## Verification
The bench builds the block with `SECTORS`=2, `SETUP_CYC`=2, `STROBE_CYC`=3, `HOLD_CYC`=1, a 12-bit RAM address and a load base of 0x100. With two sectors, the card model inserts a random busy period at the sector boundary in the middle of the transfer, and it reports data request as set while busy, so R2's rule on ignoring other bits is exercised. Setup, strobe and hold widths above one cycle make the timing checks of R9 meaningful. The nonzero base lets a write just below or just above the loaded range be detected. A second boot with an injected card error covers R8.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  // Task-file register offsets (decoded by the card)
  localparam logic [2:0] REG_DATA    = 3'd0;
  localparam logic [2:0] REG_FEAT    = 3'd1;
  localparam logic [2:0] REG_COUNT   = 3'd2;
  localparam logic [2:0] REG_LBA_LO  = 3'd3;
  localparam logic [2:0] REG_LBA_MID = 3'd4;
  localparam logic [2:0] REG_LBA_HI  = 3'd5;
  localparam logic [2:0] REG_DRVHD   = 3'd6;
  localparam logic [2:0] REG_STATCMD = 3'd7;

  // Values written
  localparam logic [7:0] VAL_DRV0_LBA = 8'hE0;
  localparam logic [7:0] VAL_8BIT     = 8'h01;
  localparam logic [7:0] CMD_SETFEAT  = 8'hEF;
  localparam logic [7:0] CMD_RDSECT   = 8'h20;

  // Status bit positions
  localparam int ST_BSY = 7;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;

  localparam int SECTOR_BYTES = 512;

  typedef enum logic [3:0] {
    SQ_WAIT_RDY, SQ_SEL_DRIVE, SQ_FEAT_ARG, SQ_FEAT_CMD, SQ_FEAT_WAIT,
    SQ_LBA_LO, SQ_LBA_MID, SQ_LBA_HI, SQ_COUNT, SQ_READ_CMD,
    SQ_POLL, SQ_FETCH, SQ_DONE, SQ_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} bus_phase_e;

  typedef struct packed {
    logic       wr;
    logic [2:0] reg_sel;
    logic [7:0] wdata;
  } bus_req_t;

  function automatic int f_total_bytes(int sectors);
    return sectors * SECTOR_BYTES;
  endfunction

  function automatic int f_access_span(int setup_c, int strobe_c, int hold_c);
    return setup_c + strobe_c + hold_c;
  endfunction

  // Register access that a sequencer state performs
  function automatic bus_req_t f_access(seq_state_e s, logic [7:0] count);
    bus_req_t r;
    r.wr      = 1'b1;
    r.reg_sel = REG_STATCMD;
    r.wdata   = 8'h00;
    case (s)
      SQ_SEL_DRIVE: begin r.reg_sel = REG_DRVHD;   r.wdata = VAL_DRV0_LBA; end
      SQ_FEAT_ARG:  begin r.reg_sel = REG_FEAT;    r.wdata = VAL_8BIT;     end
      SQ_FEAT_CMD:  begin r.reg_sel = REG_STATCMD; r.wdata = CMD_SETFEAT;  end
      SQ_LBA_LO:    r.reg_sel = REG_LBA_LO;
      SQ_LBA_MID:   r.reg_sel = REG_LBA_MID;
      SQ_LBA_HI:    r.reg_sel = REG_LBA_HI;
      SQ_COUNT:     begin r.reg_sel = REG_COUNT;   r.wdata = count;        end
      SQ_READ_CMD:  begin r.reg_sel = REG_STATCMD; r.wdata = CMD_RDSECT;   end
      SQ_FETCH:     begin r.wr = 1'b0; r.reg_sel = REG_DATA; end
      default:      r.wr = 1'b0;   // status polls
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfb_bus_port.sv
module cfb_bus_port
  import cfb_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  bus_req_t   req,
  output logic       acc_done,
  output logic [7:0] acc_rdata,
  output logic [2:0] ide_addr,
  output logic       ide_rd_n,
  output logic       ide_wr_n,
  output logic [7:0] ide_dout,
  output logic       ide_doe,
  input  logic [7:0] ide_din
);

  localparam int SPAN = f_access_span(SETUP_CYC, STROBE_CYC, HOLD_CYC);
  localparam int CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] STROBE_LAST = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);

  bus_phase_e    phase;
  logic [CW-1:0] cnt;
  bus_req_t      lat;

  // named events
  logic evt_start, evt_strobe_end, evt_hold_end;
  assign evt_start      = (phase == PH_IDLE) && req_valid && !acc_done;
  assign evt_strobe_end = (phase == PH_STROBE) && (cnt == STROBE_LAST);
  assign evt_hold_end   = (phase == PH_HOLD) && (cnt == HOLD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      lat       <= '0;
      acc_done  <= 1'b0;
      acc_rdata <= 8'h00;
    end else begin
      acc_done <= 1'b0;
      case (phase)
        PH_IDLE: if (evt_start) begin
          lat   <= req;
          phase <= PH_SETUP;
          cnt   <= '0;
        end
        PH_SETUP: begin
          if (cnt == SETUP_LAST) begin
            phase <= PH_STROBE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_STROBE: begin
          if (evt_strobe_end) begin
            phase <= PH_HOLD;
            cnt   <= '0;
            if (!lat.wr) acc_rdata <= ide_din;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (evt_hold_end) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            acc_done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign ide_addr = lat.reg_sel;
  assign ide_dout = lat.wdata;
  assign ide_doe  = lat.wr && (phase != PH_IDLE);
  assign ide_rd_n = !((phase == PH_STROBE) && !lat.wr);
  assign ide_wr_n = !((phase == PH_STROBE) && lat.wr);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_rd_n && !ide_wr_n)); // R9

  AST_ADDR_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ide_rd_n || !ide_wr_n) && $past(!ide_rd_n || !ide_wr_n)) |-> $stable(ide_addr)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done); // R9

  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ide_rd_n) || $rose(ide_wr_n)) |-> $stable(ide_addr)); // R9

endmodule

// File: rtl/cfb_load_ctr.sv
module cfb_load_ctr #(
  parameter int              AW    = 16,
  parameter logic [AW-1:0]   BASE  = '0,
  parameter int              TOTAL = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] addr
);

  localparam int NW = $clog2(TOTAL + 1);

  logic [NW-1:0] loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= BASE;
      loaded <= '0;
    end else if (step) begin
      addr   <= addr + 1'b1;
      loaded <= loaded + 1'b1;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr == $past(addr) + 1'b1); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(addr)); // R6

  AST_LOAD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> loaded < NW'(TOTAL)); // R6

endmodule

// File: rtl/cfb_sequencer.sv
module cfb_sequencer
  import cfb_pkg::*;
#(
  parameter int SECTORS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_done,
  input  logic [7:0] acc_rdata,
  output logic       acc_valid,
  output bus_req_t   acc_req,
  output logic       ram_we,
  output logic [7:0] ram_wdata,
  output logic       boot_done,
  output logic       boot_err
);

  localparam logic [7:0] COUNT8 = 8'(SECTORS);

  seq_state_e state, nxt;
  logic       last_stat_bsy;

  // named events
  logic is_status_read, evt_status_clear, evt_fault_seen, evt_byte_taken, evt_cmd_write;
  assign is_status_read   = !acc_req.wr && (acc_req.reg_sel == REG_STATCMD);
  assign evt_status_clear = acc_done && is_status_read && !acc_rdata[ST_BSY];
  assign evt_fault_seen   = evt_status_clear && acc_rdata[ST_ERR] &&
                            (state == SQ_FEAT_WAIT || state == SQ_POLL);
  assign evt_byte_taken   = acc_done && (state == SQ_FETCH);
  assign evt_cmd_write    = acc_done && acc_req.wr && (acc_req.reg_sel == REG_STATCMD);

  assign acc_valid = (state != SQ_DONE) && (state != SQ_FAULT);
  assign acc_req   = f_access(state, COUNT8);

  always_comb begin
    nxt = state;
    if (acc_done) begin
      case (state)
        SQ_WAIT_RDY:  if (evt_status_clear) nxt = SQ_SEL_DRIVE;
        SQ_SEL_DRIVE: nxt = SQ_FEAT_ARG;
        SQ_FEAT_ARG:  nxt = SQ_FEAT_CMD;
        SQ_FEAT_CMD:  nxt = SQ_FEAT_WAIT;
        SQ_FEAT_WAIT: if (evt_fault_seen) nxt = SQ_FAULT;
                      else if (evt_status_clear) nxt = SQ_LBA_LO;
        SQ_LBA_LO:    nxt = SQ_LBA_MID;
        SQ_LBA_MID:   nxt = SQ_LBA_HI;
        SQ_LBA_HI:    nxt = SQ_COUNT;
        SQ_COUNT:     nxt = SQ_READ_CMD;
        SQ_READ_CMD:  nxt = SQ_POLL;
        SQ_POLL: begin
          if (evt_fault_seen) nxt = SQ_FAULT;
          else if (evt_status_clear) nxt = acc_rdata[ST_DRQ] ? SQ_FETCH : SQ_DONE;
        end
        SQ_FETCH:     nxt = SQ_POLL;
        default:      nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= SQ_WAIT_RDY;
      last_stat_bsy <= 1'b1;
      ram_we        <= 1'b0;
      ram_wdata     <= 8'h00;
    end else begin
      state  <= nxt;
      ram_we <= evt_byte_taken;
      if (evt_byte_taken) ram_wdata <= acc_rdata;
      if (acc_done && is_status_read) last_stat_bsy <= acc_rdata[ST_BSY];
    end
  end

  assign boot_done = (state == SQ_DONE);
  assign boot_err  = (state == SQ_FAULT);

  AST_CMD_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd_write |-> !last_stat_bsy); // R2

  AST_WE_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(state) == SQ_FETCH); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done && !boot_err); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_err |=> boot_err && !ram_we); // R8

  AST_FETCH_AFTER_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_FETCH && $past(state) != SQ_FETCH) |-> $past(acc_rdata[ST_DRQ])); // R5

endmodule

// File: rtl/cf_boot_loader.sv
module cf_boot_loader
  import cfb_pkg::*;
#(
  parameter int                  SECTORS    = 1,
  parameter int                  RAM_AW     = 16,
  parameter logic [RAM_AW-1:0]   LOAD_BASE  = 'h0200,
  parameter int                  SETUP_CYC  = 1,
  parameter int                  STROBE_CYC = 2,
  parameter int                  HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [2:0]        ide_addr,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic [7:0]        ide_dout,
  output logic              ide_doe,
  input  logic [7:0]        ide_din,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              boot_done,
  output logic              boot_err,
  output logic              cpu_rst_n
);

  localparam int TOTAL = f_total_bytes(SECTORS);

  logic       acc_valid, acc_done;
  bus_req_t   acc_req;
  logic [7:0] acc_rdata;
  logic       cpu_rel_q;

  cfb_sequencer #(.SECTORS(SECTORS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_done  (acc_done),
    .acc_rdata (acc_rdata),
    .acc_valid (acc_valid),
    .acc_req   (acc_req),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .boot_done (boot_done),
    .boot_err  (boot_err)
  );

  cfb_bus_port #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (acc_valid),
    .req       (acc_req),
    .acc_done  (acc_done),
    .acc_rdata (acc_rdata),
    .ide_addr  (ide_addr),
    .ide_rd_n  (ide_rd_n),
    .ide_wr_n  (ide_wr_n),
    .ide_dout  (ide_dout),
    .ide_doe   (ide_doe),
    .ide_din   (ide_din)
  );

  cfb_load_ctr #(
    .AW    (RAM_AW),
    .BASE  (LOAD_BASE),
    .TOTAL (TOTAL)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ram_we),
    .addr  (ram_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_rel_q <= 1'b0;
    else        cpu_rel_q <= boot_done;
  end
  assign cpu_rst_n = cpu_rel_q;

  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(boot_done)); // R7

  AST_HELD_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    boot_err |-> !cpu_rst_n); // R8

  AST_NO_ACCESS_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done || boot_err) && $past(boot_done || boot_err) |-> ide_rd_n && ide_wr_n); // R8

  AST_EXCLUSIVE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(boot_done && boot_err)); // R7

endmodule

// File: tb/test_cf_boot_loader.sv
module test_cf_boot_loader;

  localparam int SECT   = 2;
  localparam int AW     = 12;
  localparam int BASE   = 'h100;
  localparam int SETUP  = 2;
  localparam int STROBE = 3;
  localparam int HOLD   = 1;
  localparam int TOTAL  = SECT * 512;
  localparam int LIMIT  = 150000;

  // expected register writes {offset, value}
  localparam logic [10:0] EXP_WR [8] = '{
    {3'd6, 8'hE0}, {3'd1, 8'h01}, {3'd7, 8'hEF},
    {3'd3, 8'h00}, {3'd4, 8'h00}, {3'd5, 8'h00},
    {3'd2, 8'(SECT)}, {3'd7, 8'h20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [2:0]    ide_addr;
  logic          ide_rd_n, ide_wr_n, ide_doe;
  logic [7:0]    ide_dout, ide_din;
  logic          ram_we, boot_done, boot_err, cpu_rst_n;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;

  cf_boot_loader #(
    .SECTORS(SECT), .RAM_AW(AW), .LOAD_BASE(AW'(BASE)),
    .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD)
  ) i_cf_boot_loader (
    .clk(clk), .rst_n(rst_n), .ide_addr(ide_addr), .ide_rd_n(ide_rd_n),
    .ide_wr_n(ide_wr_n), .ide_dout(ide_dout), .ide_doe(ide_doe), .ide_din(ide_din),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .boot_done(boot_done), .boot_err(boot_err), .cpu_rst_n(cpu_rst_n)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) ^ (i >> 8));
  endfunction

  // ---------------- card model and monitors (negedge) ----------------
  bit          inject_err;
  int          bsy, remaining, rd_idx, wcount, ram_cnt, first_addr;
  bit          err_flag, armed;
  bit          busy_write_viol, early_read_viol, strobe_viol, setup_viol, hold_viol;
  logic [10:0] wlog [16];
  logic [7:0]  mem [4096];
  logic        prev_rd, prev_wr;
  logic [2:0]  prev_addr;
  int          low_len, stable_len, since_rise;
  logic [7:0]  status;

  always_comb begin
    if (bsy > 0) status = 8'h88;   // busy, data-request bit is garbage
    else status = {1'b0, 1'b1, 2'b00, (armed && remaining > 0), 2'b00, err_flag};
  end
  assign ide_din = (ide_addr == 3'd7) ? status :
                   (ide_addr == 3'd0) ? pat(rd_idx) : 8'h00;

  always @(negedge clk) begin
    if (!rst_n) begin
      bsy <= 25; remaining <= 0; rd_idx <= 0; wcount <= 0; ram_cnt <= 0;
      first_addr <= -1; err_flag <= 0; armed <= 0;
      busy_write_viol <= 0; early_read_viol <= 0;
      strobe_viol <= 0; setup_viol <= 0; hold_viol <= 0;
      prev_rd <= 1; prev_wr <= 1; prev_addr <= ide_addr;
      low_len <= 0; stable_len <= 0; since_rise <= 100;
    end else begin
      prev_rd <= ide_rd_n; prev_wr <= ide_wr_n; prev_addr <= ide_addr;
      if (bsy > 0) bsy <= bsy - 1;
      // write capture on strobe rise
      if (ide_wr_n && !prev_wr) begin
        if (wcount < 16) wlog[wcount] <= {ide_addr, ide_dout};
        wcount <= wcount + 1;
        if (bsy > 0) busy_write_viol <= 1;
        if (ide_addr == 3'd7 && ide_dout == 8'hEF) bsy <= int'($urandom_range(40, 3));
        if (ide_addr == 3'd7 && ide_dout == 8'h20) begin
          bsy <= int'($urandom_range(40, 3));
          armed <= 1;
          if (inject_err) err_flag <= 1;
          else remaining <= TOTAL;
        end
      end
      // data read on strobe rise
      if (ide_rd_n && !prev_rd && ide_addr == 3'd0) begin
        if (!(armed && remaining > 0) || bsy > 0) early_read_viol <= 1;
        rd_idx <= rd_idx + 1;
        remaining <= remaining - 1;
        if (remaining - 1 > 0 && (remaining - 1) % 512 == 0)
          bsy <= int'($urandom_range(40, 3));
      end
      // timing monitors
      if (ide_addr != prev_addr) begin
        stable_len <= 1;
        if (since_rise <= HOLD) hold_viol <= 1;
      end else stable_len <= stable_len + 1;
      if (!ide_rd_n && !ide_wr_n) strobe_viol <= 1;
      if (!ide_rd_n || !ide_wr_n) begin
        low_len <= low_len + 1;
        since_rise <= 0;
        if ((prev_rd && prev_wr) && !(ide_addr != prev_addr) && stable_len + 1 <= SETUP)
          setup_viol <= 1;
        if ((prev_rd && prev_wr) && (ide_addr != prev_addr)) setup_viol <= 1;
      end else begin
        if (!(prev_rd && prev_wr) && low_len != STROBE) strobe_viol <= 1;
        low_len <= 0;
        since_rise <= since_rise + 1;
      end
      if (ram_we) begin
        mem[ram_addr] <= ram_wdata;
        ram_cnt <= ram_cnt + 1;
        if (first_addr < 0) first_addr <= int'(ram_addr);
      end
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_end(input bit for_err, output bit timed_out);
    int c;
    c = 0;
    while (c < LIMIT && !(for_err ? boot_err : boot_done)) begin
      @(negedge clk);
      c++;
    end
    timed_out = (c >= LIMIT);
  endtask

  initial begin
    bit to;
    int bad;
    bit hung;
    hung = 0;
    inject_err = 0;
    for (int a = 0; a < 4096; a++) mem[a] = 8'hA5;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(cpu_rst_n == 0 && boot_done == 0 && boot_err == 0, "R1", "end flags in reset",
        {cpu_rst_n, boot_done, boot_err}, 0);
    chk(ide_rd_n == 1 && ide_wr_n == 1 && ram_we == 0, "R1", "strobes in reset",
        {ide_rd_n, ide_wr_n, ram_we}, 6);
    rst_n = 1;
    wait_end(0, to);
    if (to) begin
      hung = 1;
      chk(0, "R7", "watchdog on good load", 0, 1);
    end
    if (!hung) begin
      repeat (3) @(negedge clk);
      chk(wcount == 8, "R4", "register write count", wcount, 8);
      for (int k = 0; k < 8; k++)
        chk(wlog[k] == EXP_WR[k], (k < 3) ? "R3" : "R4", $sformatf("write #%0d", k),
            wlog[k], EXP_WR[k]);
      chk(!busy_write_viol, "R2", "write while busy", busy_write_viol, 0);
      chk(!early_read_viol && rd_idx == TOTAL, "R5", "data reads", rd_idx, TOTAL);
      chk(ram_cnt == TOTAL, "R6", "ram write count", ram_cnt, TOTAL);
      chk(first_addr == BASE, "R6", "first ram address", first_addr, BASE);
      bad = 0;
      for (int i = 0; i < TOTAL; i++) if (mem[BASE + i] != pat(i)) bad++;
      chk(bad == 0, "R6", "ram content mismatches", bad, 0);
      chk(mem[BASE - 1] == 8'hA5 && mem[BASE + TOTAL] == 8'hA5, "R6", "bytes outside range",
          {mem[BASE - 1], mem[BASE + TOTAL]}, 16'hA5A5);
      chk(boot_done && cpu_rst_n && !boot_err, "R7", "release after load",
          {boot_done, cpu_rst_n, boot_err}, 6);
      chk(!strobe_viol, "R9", "strobe width/overlap", strobe_viol, 0);
      chk(!setup_viol && !hold_viol, "R9", "address setup/hold", {setup_viol, hold_viol}, 0);

      // error run
      rst_n = 0;
      inject_err = 1;
      for (int a = 0; a < 4096; a++) mem[a] = 8'hA5;
      repeat (3) @(negedge clk);
      chk(cpu_rst_n == 0 && boot_done == 0, "R1", "reset after done", {cpu_rst_n, boot_done}, 0);
      rst_n = 1;
      wait_end(1, to);
      if (to) chk(0, "R8", "watchdog on error load", 0, 1);
      else begin
        repeat (60) @(negedge clk);
        chk(boot_err && !cpu_rst_n && !boot_done, "R8", "error stop state",
            {boot_err, cpu_rst_n, boot_done}, 4);
        chk(wcount == 8 && ram_cnt == 0 && rd_idx == 0, "R8", "activity after error",
            wcount * 10000 + ram_cnt * 100 + rd_idx, 80000);
      end
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule